// File: doc/BRIEF.md
# Shared-Pin Timer and Event Counter

A single-channel timer/event counter with a small register interface and one I/O pin that it shares with a general-purpose function. Software programs a control word, a load value and a compare value. While the counter is enabled, single-cycle `tick` pulses advance it. Whether it reloads, and when, depends on the mode field and the reload bit.

The mode field sorts the counter into groups. Plain timer modes are 0 to 3 and watchdog modes are 9 and 10. Both preload on the first event after enabling and reload on a compare match. Modes 4 and 5 are the measurement group, which preloads on a rising edge of the sampled pin. Mode 7 is the PWM mode, which reloads on overflow. Every other value only counts.

When the mode field is zero, the pin becomes a general-purpose pin. Its direction is selectable and its polarity can be inverted. In mode 7 the pin carries the PWM level. In all other modes the pin is released.

Top module: `tmr_evcnt`

## Requirements
- R1: After reset, the control word, load, compare and count registers all read 0, and `pin_oe` and `pin_out` are 0.
- R2: While the enable bit (control bit 0) is 0, the count does not change. Clearing the enable bit also clears the internal started flag.
- R3: In modes 0 to 3 and 9 to 10, the first `tick` after enabling copies the load register into the count.
- R4: In those same modes, once started, with the reload bit (control bit 5) set, a `tick` that arrives while the count equals the compare register loads the load register instead of incrementing.
- R5: If the enable bit is set and no reload rule applies, each `tick` adds 1 to the count. The count wraps from all ones to 0.
- R6: In mode 7 with the reload bit set, a `tick` at count all ones loads the load register.
- R7: In modes 4 and 5 with the enable and reload bits set, a rising edge of the data-in bit loads the load register. This preload takes priority over a `tick` in the same cycle.
- R8: The data-in bit (control bit 8, read-only) takes the value of `pin_in` XOR the invert bit (control bit 7) one clock after `pin_in` is sampled.
- R9: When the mode field (control bits 4:1) is 0 and the direction bit (control bit 6) is 1, `pin_oe` is 1 and `pin_out` equals the data-out bit (control bit 9) XOR the invert bit. When the mode field is 0 and the direction bit is 0, `pin_oe` is 0.
- R10: When the mode field is not 0, the direction bit is ignored. `pin_oe` is 1 only in mode 7, and in that mode `pin_out` equals (count >= compare) XOR the invert bit. Whenever `pin_oe` is 0, `pin_out` is 0.
- R11: A control write changes the data-out bit only if the mode field held before that write is 0. Otherwise the data-out bit keeps its value.
- R12: Register map: address 0 is the control word, address 1 is the load register, address 2 is the compare register, and address 3 is the count, which is read-only. Writes to address 3 are ignored. A write takes effect at the next clock edge, and `rd_data` follows `rd_addr` combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Single-cycle counting event |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address |
| wr_data | input | 24 | Write data |
| rd_addr | input | 2 | Read address |
| rd_data | output | 24 | Read data for `rd_addr` |
| pin_in | input | 1 | Level sensed on the shared pin |
| pin_oe | output | 1 | Drive enable for the shared pin |
| pin_out | output | 1 | Value driven on the shared pin |

## Verification
The hardest state to reach is the PWM overflow reload, because software cannot write the count. The bench gets there in three steps. It first disables the counter and loads a value a few steps below all ones. It then re-enables the counter in a timer mode, so the first tick copies that value into the count. Finally it switches to mode 7 without disabling, so the ticks that follow walk the count through the overflow. Random segments use small load and compare values so that compare-match reloads happen often, and they toggle the pin during measurement modes so that edge preloads collide with ticks.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int unsigned BIT_EN   = 0;
  localparam int unsigned MODE_LO  = 1;
  localparam int unsigned MODE_W   = 4;
  localparam int unsigned BIT_RL   = 5;
  localparam int unsigned BIT_DIR  = 6;
  localparam int unsigned BIT_INV  = 7;
  localparam int unsigned BIT_DI   = 8;
  localparam int unsigned BIT_DO   = 9;
  localparam int unsigned CTRL_USED = 10;

  localparam logic [1:0] A_CTRL = 2'd0;
  localparam logic [1:0] A_LOAD = 2'd1;
  localparam logic [1:0] A_CMP  = 2'd2;
  localparam logic [1:0] A_CNT  = 2'd3;

  localparam logic [MODE_W-1:0] MODE_PWM = 4'd7;

  typedef enum logic [2:0] {
    GRP_TIMER,
    GRP_MEAS,
    GRP_PWM,
    GRP_WDOG,
    GRP_OTHER
  } grp_e;

  function automatic grp_e mode_group(input logic [MODE_W-1:0] m);
    if (m <= 4'd3)                    return GRP_TIMER;
    else if (m == 4'd4 || m == 4'd5)  return GRP_MEAS;
    else if (m == MODE_PWM)           return GRP_PWM;
    else if (m == 4'd9 || m == 4'd10) return GRP_WDOG;
    else                              return GRP_OTHER;
  endfunction

  function automatic logic match_group(input grp_e g);
    return (g == GRP_TIMER) || (g == GRP_WDOG);
  endfunction
endpackage

// File: rtl/tmr_regs.sv
module tmr_regs
  import tmr_pkg::*;
#(
  parameter int unsigned DW = 24,
  parameter int unsigned AW = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [AW-1:0]     wr_addr,
  input  logic [DW-1:0]     wr_data,
  input  logic [AW-1:0]     rd_addr,
  input  logic [DW-1:0]     cnt,
  input  logic              di,
  output logic              en_q,
  output logic [MODE_W-1:0] mode_q,
  output logic              rl_q,
  output logic              dir_q,
  output logic              inv_q,
  output logic              do_q,
  output logic [DW-1:0]     load_q,
  output logic [DW-1:0]     cmp_q,
  output logic [DW-1:0]     rd_data
);
  localparam int unsigned PAD = DW - CTRL_USED;

  logic wr_ctrl, wr_load, wr_cmp;
  logic [DW-1:0] ctrl_word;
  logic unused_bits;

  assign wr_ctrl = wr_en && (wr_addr == AW'(A_CTRL));
  assign wr_load = wr_en && (wr_addr == AW'(A_LOAD));
  assign wr_cmp  = wr_en && (wr_addr == AW'(A_CMP));
  assign unused_bits = ^{wr_data[DW-1:CTRL_USED], wr_data[BIT_DI]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      mode_q <= '0;
      rl_q   <= 1'b0;
      dir_q  <= 1'b0;
      inv_q  <= 1'b0;
      do_q   <= 1'b0;
    end else if (wr_ctrl) begin
      en_q   <= wr_data[BIT_EN];
      mode_q <= wr_data[MODE_LO +: MODE_W];
      rl_q   <= wr_data[BIT_RL];
      dir_q  <= wr_data[BIT_DIR];
      inv_q  <= wr_data[BIT_INV];
      if (mode_q == '0) do_q <= wr_data[BIT_DO];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      load_q <= '0;
      cmp_q  <= '0;
    end else begin
      if (wr_load) load_q <= wr_data;
      if (wr_cmp)  cmp_q  <= wr_data;
    end
  end

  assign ctrl_word = {{PAD{1'b0}}, do_q, di, inv_q, dir_q, rl_q, mode_q, en_q};

  always_comb begin
    unique case (rd_addr)
      AW'(A_CTRL): rd_data = ctrl_word;
      AW'(A_LOAD): rd_data = load_q;
      AW'(A_CMP):  rd_data = cmp_q;
      default:     rd_data = cnt;
    endcase
  end
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter
  import tmr_pkg::*;
#(
  parameter int unsigned DW = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic [MODE_W-1:0] mode,
  input  logic              rl,
  input  logic              tick,
  input  logic              meas_edge,
  input  logic [DW-1:0]     load_val,
  input  logic [DW-1:0]     cmp_val,
  output logic [DW-1:0]     cnt_q,
  output logic              ev_first_load,
  output logic              ev_cmp_reload,
  output logic              ev_ovf_reload,
  output logic              ev_edge_preload
);
  localparam logic [DW-1:0] CNT_MAX = '1;

  function automatic logic [DW-1:0] bump(input logic [DW-1:0] v);
    return v + 1'b1;
  endfunction

  grp_e grp;
  logic started_q;
  logic [DW-1:0] cnt_d;
  logic step_ok;

  assign grp     = mode_group(mode);
  assign step_ok = en && tick;

  always_comb begin
    ev_first_load   = step_ok && !started_q && match_group(grp);
    ev_cmp_reload   = step_ok && started_q && rl && match_group(grp) && (cnt_q == cmp_val);
    ev_ovf_reload   = step_ok && rl && (grp == GRP_PWM) && (cnt_q == CNT_MAX);
    ev_edge_preload = en && rl && (grp == GRP_MEAS) && meas_edge;
    cnt_d = cnt_q;
    if (ev_first_load || ev_cmp_reload || ev_ovf_reload || ev_edge_preload)
      cnt_d = load_val;
    else if (step_ok)
      cnt_d = bump(cnt_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q     <= '0;
      started_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      if (!en)       started_q <= 1'b0;
      else if (tick) started_q <= 1'b1;
    end
  end
endmodule

// File: rtl/tmr_pin.sv
module tmr_pin
  import tmr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pin_in,
  input  logic [MODE_W-1:0] mode,
  input  logic              dir,
  input  logic              inv,
  input  logic              dout,
  input  logic              pwm_hi,
  output logic              di_q,
  output logic              meas_edge,
  output logic              pin_oe,
  output logic              pin_out
);
  logic di_prev_q;
  logic gpio_on, pwm_on;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      di_q      <= 1'b0;
      di_prev_q <= 1'b0;
    end else begin
      di_q      <= pin_in ^ inv;
      di_prev_q <= di_q;
    end
  end

  assign meas_edge = di_q && !di_prev_q;
  assign gpio_on   = (mode == '0);
  assign pwm_on    = (mode == MODE_PWM);

  always_comb begin
    pin_oe  = 1'b0;
    pin_out = 1'b0;
    if (gpio_on && dir) begin
      pin_oe  = 1'b1;
      pin_out = dout ^ inv;
    end else if (pwm_on) begin
      pin_oe  = 1'b1;
      pin_out = pwm_hi ^ inv;
    end
  end
endmodule

// File: rtl/tmr_evcnt.sv
module tmr_evcnt
  import tmr_pkg::*;
#(
  parameter int unsigned DW = 24,
  parameter int unsigned AW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data,
  input  logic          pin_in,
  output logic          pin_oe,
  output logic          pin_out
);
  logic              en_q, rl_q, dir_q, inv_q, do_q, di_q;
  logic [MODE_W-1:0] mode_q;
  logic [DW-1:0]     load_q, cmp_q, cnt_q;
  logic              meas_edge, pwm_hi;
  logic              ev_first_load, ev_cmp_reload, ev_ovf_reload, ev_edge_preload;

  assign pwm_hi = (cnt_q >= cmp_q);

  tmr_regs #(.DW(DW), .AW(AW)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .cnt(cnt_q), .di(di_q),
    .en_q(en_q), .mode_q(mode_q), .rl_q(rl_q), .dir_q(dir_q), .inv_q(inv_q), .do_q(do_q),
    .load_q(load_q), .cmp_q(cmp_q), .rd_data(rd_data)
  );

  tmr_counter #(.DW(DW)) u_cnt (
    .clk(clk), .rst_n(rst_n), .en(en_q), .mode(mode_q), .rl(rl_q), .tick(tick),
    .meas_edge(meas_edge), .load_val(load_q), .cmp_val(cmp_q), .cnt_q(cnt_q),
    .ev_first_load(ev_first_load), .ev_cmp_reload(ev_cmp_reload),
    .ev_ovf_reload(ev_ovf_reload), .ev_edge_preload(ev_edge_preload)
  );

  tmr_pin u_pin (
    .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .mode(mode_q), .dir(dir_q), .inv(inv_q),
    .dout(do_q), .pwm_hi(pwm_hi), .di_q(di_q), .meas_edge(meas_edge),
    .pin_oe(pin_oe), .pin_out(pin_out)
  );
endmodule

// File: rtl/tmr_evcnt_chk.sv
module tmr_evcnt_chk #(
  parameter int unsigned DW = 24,
  parameter int unsigned AW = 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_en,
  input logic [AW-1:0] wr_addr,
  input logic          pin_in,
  input logic          pin_oe,
  input logic          pin_out,
  input logic          en_q,
  input logic [3:0]    mode_q,
  input logic          dir_q,
  input logic          inv_q,
  input logic          do_q,
  input logic          di_q,
  input logic [DW-1:0] load_q,
  input logic [DW-1:0] cnt_q,
  input logic          ev_first_load,
  input logic          ev_cmp_reload,
  input logic          ev_ovf_reload,
  input logic          ev_edge_preload
);
  // R2
  hold_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q |=> $stable(cnt_q));
  // R3
  first_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_first_load |=> (cnt_q == $past(load_q)));
  // R4
  cmp_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_cmp_reload |=> (cnt_q == $past(load_q)));
  // R6
  ovf_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_ovf_reload |=> (cnt_q == $past(load_q)));
  // R7
  edge_preload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_edge_preload |=> (cnt_q == $past(load_q)));
  // R8
  di_sample_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (di_q == $past(pin_in ^ inv_q)));
  // R9
  gpio_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == 4'd0 && dir_q) |-> (pin_oe && pin_out == (do_q ^ inv_q)));
  // R10
  pin_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q != 4'd0 && mode_q != 4'd7) |-> (!pin_oe && !pin_out));
  // R11
  do_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == AW'(0) && mode_q != 4'd0) |=> $stable(do_q));
  // R12
  cnt_ro_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == AW'(3) && !en_q) |=> $stable(cnt_q));
endmodule

bind tmr_evcnt tmr_evcnt_chk #(.DW(DW), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .pin_in(pin_in),
  .pin_oe(pin_oe), .pin_out(pin_out), .en_q(en_q), .mode_q(mode_q), .dir_q(dir_q),
  .inv_q(inv_q), .do_q(do_q), .di_q(di_q), .load_q(load_q), .cnt_q(cnt_q),
  .ev_first_load(ev_first_load), .ev_cmp_reload(ev_cmp_reload),
  .ev_ovf_reload(ev_ovf_reload), .ev_edge_preload(ev_edge_preload)
);

// File: tb/tmr_evcnt_bench.sv
module tmr_evcnt_bench;
  localparam int DW = 24;
  localparam logic [DW-1:0] ALL1 = '1;

  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0, wr_en = 1'b0, pin_in = 1'b0;
  logic [1:0] wr_addr = '0, rd_addr = 2'd3;
  logic [DW-1:0] wr_data = '0;
  logic [DW-1:0] rd_data;
  logic pin_oe, pin_out;

  int checks = 0, errors = 0;
  bit done = 0;

  // reference state
  bit m_en, m_rl, m_dir, m_inv, m_do, m_di, m_dip, m_st;
  logic [3:0] m_mode;
  logic [DW-1:0] m_cnt, m_load, m_cmp;

  always #4 clk = ~clk;

  tmr_evcnt u_tmr_evcnt (
    .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .pin_in(pin_in),
    .pin_oe(pin_oe), .pin_out(pin_out)
  );

  function automatic int grp_of(input logic [3:0] m);
    if (m <= 3) return 0;
    if (m == 4 || m == 5) return 1;
    if (m == 7) return 2;
    if (m == 9 || m == 10) return 3;
    return 4;
  endfunction

  function automatic logic [DW-1:0] ctrl_exp();
    logic [DW-1:0] w = '0;
    w[0] = m_en; w[4:1] = m_mode; w[5] = m_rl; w[6] = m_dir;
    w[7] = m_inv; w[8] = m_di; w[9] = m_do;
    return w;
  endfunction

  function automatic logic [DW-1:0] ctrl_val(input bit en, input int mode, input bit rl,
                                             input bit dir, input bit inv, input bit dout);
    return DW'(en) | DW'(mode << 1) | DW'(rl) << 5 | DW'(dir) << 6 | DW'(inv) << 7 | DW'(dout) << 9;
  endfunction

  task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic check_pins();
    bit eoe, eout;
    eoe = 0; eout = 0;
    if (m_mode == 0 && m_dir) begin eoe = 1; eout = m_do ^ m_inv; end
    else if (m_mode == 7) begin eoe = 1; eout = (m_cnt >= m_cmp) ^ m_inv; end
    check(m_mode == 0 ? "R9 pin_oe" : "R10 pin_oe", DW'(pin_oe), DW'(eoe));
    check(m_mode == 0 ? "R9 pin_out" : "R10 pin_out", DW'(pin_out), DW'(eout));
  endtask

  task automatic step(input bit tk, input bit pin, input bit wr, input logic [1:0] wa,
                      input logic [DW-1:0] wd);
    int g;
    bit edge_now, n_st;
    logic [DW-1:0] n_cnt;
    string tag;
    @(negedge clk);
    tick = tk; pin_in = pin; wr_en = wr; wr_addr = wa; wr_data = wd;
    g = grp_of(m_mode);
    edge_now = m_di & ~m_dip;
    n_cnt = m_cnt; tag = "R5";
    if (!m_en) tag = "R2";
    else if ((g == 0 || g == 3) && tk && !m_st) begin n_cnt = m_load; tag = "R3"; end
    else if ((g == 0 || g == 3) && tk && m_rl && m_cnt == m_cmp) begin n_cnt = m_load; tag = "R4"; end
    else if (g == 2 && tk && m_rl && m_cnt == ALL1) begin n_cnt = m_load; tag = "R6"; end
    else if (g == 1 && m_rl && edge_now) begin n_cnt = m_load; tag = "R7"; end
    else if (tk) n_cnt = m_cnt + 1'b1;
    n_st = m_en ? (m_st | tk) : 1'b0;
    @(posedge clk);
    #1;
    m_cnt = n_cnt; m_st = n_st;
    m_dip = m_di; m_di = pin ^ m_inv;
    if (wr) begin
      case (wa)
        2'd0: begin
          if (m_mode == 0) m_do = wd[9];
          m_en = wd[0]; m_mode = wd[4:1]; m_rl = wd[5]; m_dir = wd[6]; m_inv = wd[7];
        end
        2'd1: m_load = wd;
        2'd2: m_cmp = wd;
        default: ;
      endcase
      if (wa == 2'd3) tag = "R12";
    end
    wr_en = 0; tick = 0;
    rd_addr = 2'd3; #1;
    check(tag, rd_data, m_cnt);
    rd_addr = 2'd0; #1;
    check("R8 R11 ctrl", rd_data, ctrl_exp());
    rd_addr = 2'd3;
    check_pins();
  endtask

  task automatic wreg(input logic [1:0] a, input logic [DW-1:0] d);
    step(0, pin_in, 1, a, d);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) step(1, pin_in, 0, 2'd0, '0);
  endtask

  initial begin
    m_en = 0; m_rl = 0; m_dir = 0; m_inv = 0; m_do = 0; m_di = 0; m_dip = 0; m_st = 0;
    m_mode = 0; m_cnt = 0; m_load = 0; m_cmp = 0;
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    // R1 reset state
    for (int a = 0; a < 4; a++) begin
      rd_addr = 2'(a); #1;
      check("R1 reset reg", rd_data, '0);
    end
    rd_addr = 2'd3;
    check("R1 reset pin_oe", DW'(pin_oe), '0);
    check("R1 reset pin_out", DW'(pin_out), '0);

    // R3, R4: timer with compare reload
    wreg(2'd1, 24'd5); wreg(2'd2, 24'd8);
    wreg(2'd0, ctrl_val(1, 1, 1, 0, 0, 0));
    ticks(10);
    // R2: disabled hold
    wreg(2'd0, ctrl_val(0, 1, 1, 0, 0, 0));
    ticks(3);
    // R12: write to count ignored
    wreg(2'd3, 24'h00ABCD);
    // R5: free run past compare in mode 3
    wreg(2'd0, ctrl_val(1, 3, 0, 0, 0, 0));
    ticks(12);
    // R6: walk to overflow in PWM
    wreg(2'd0, ctrl_val(0, 1, 0, 0, 0, 0));
    wreg(2'd1, 24'hFFFFFC); wreg(2'd2, 24'hFFFFFE);
    wreg(2'd0, ctrl_val(1, 1, 0, 0, 0, 0));
    ticks(1);
    wreg(2'd0, ctrl_val(1, 7, 1, 1, 0, 0));
    ticks(6);
    wreg(2'd0, ctrl_val(1, 7, 0, 0, 1, 0));
    ticks(6);
    // R7: edge preload in measurement mode, colliding with ticks
    wreg(2'd1, 24'd40);
    wreg(2'd0, ctrl_val(1, 4, 1, 0, 0, 0));
    step(1, 0, 0, 0, '0); step(1, 1, 0, 0, '0); step(1, 1, 0, 0, '0); step(1, 1, 0, 0, '0);
    step(1, 0, 0, 0, '0); step(0, 1, 0, 0, '0); step(0, 1, 0, 0, '0); step(1, 1, 0, 0, '0);
    // R11: data-out write ignored while mode nonzero, direction ignored (R10)
    wreg(2'd0, ctrl_val(1, 5, 0, 1, 0, 1));
    wreg(2'd0, ctrl_val(0, 0, 0, 1, 0, 1));
    // R9: GPIO output, then with invert, then input
    wreg(2'd0, ctrl_val(0, 0, 0, 1, 0, 1));
    wreg(2'd0, ctrl_val(0, 0, 0, 1, 1, 1));
    // R8: data-in with inversion
    step(0, 1, 0, 0, '0); step(0, 0, 0, 0, '0);
    wreg(2'd0, ctrl_val(0, 0, 0, 0, 0, 0));
    step(0, 1, 0, 0, '0); step(0, 1, 0, 0, '0);

    // random segments
    for (int s = 0; s < 60; s++) begin
      int modes [10] = '{0, 1, 2, 3, 4, 5, 7, 9, 10, 12};
      int ld;
      ld = ($urandom % 4 == 0) ? int'(24'hFFFFF0 + ($urandom % 8)) : int'($urandom % 16);
      wreg(2'd1, DW'(ld));
      wreg(2'd2, DW'(ld + int'($urandom % 6)));
      wreg(2'd0, ctrl_val(($urandom % 8) != 0, modes[$urandom % 10], $urandom % 2,
                          $urandom % 2, $urandom % 2, $urandom % 2));
      for (int c = 0; c < 40; c++) begin
        bit p;
        p = ($urandom % 5 == 0) ? ~pin_in : pin_in;
        if ($urandom % 25 == 0)
          step($urandom % 10 < 6, p, 1, 2'd0,
               ctrl_val(($urandom % 6) != 0, modes[$urandom % 10], $urandom % 2,
                        $urandom % 2, $urandom % 2, $urandom % 2));
        else if ($urandom % 40 == 0)
          step($urandom % 10 < 6, p, 1, 2'(1 + $urandom % 3), DW'($urandom % 16));
        else
          step($urandom % 10 < 6, p, 0, 2'd0, '0);
      end
    end
    done = 1;
  end

  initial begin
    for (int i = 0; i < 200000 && !done; i++) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected finished");
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule